// File: doc/BRIEF.md
# Registered Sixteen-Bit Multi-Function ALU

This block is a small registered datapath. Two operand registers, A and B, capture input words when their own load enables are high. A combinational unit works on the registered operands under a 3-bit operation code. On each clock edge its result goes into an output register, together with a carry flag. Available operations are hold, copy of A, addition, subtraction, a variable left shift of A, bitwise OR, bitwise AND and a multiply truncated to the word width.

Addition and subtraction share one ripple carry chain. Subtraction feeds the chain with the inverted B word and a carry-in of one. The subtract select is decoded from the complete operation code, and the adder operands are forced to zero for any other operation so that the chain stays quiet. The operation code is not registered. The result captured at an edge comes from the operand register contents present just before that edge, so a word loaded at an edge is first used one cycle later. A and B may be reloaded in the same cycle that an operation consumes their previous contents.

Top module: `alu16_core`

## Requirements
- R1: A synchronous active-high reset clears both operand registers, the result register and the carry flag to zero.
- R2: With operation code 000 (hold), the result register and the carry flag keep their previous values.
- R3: With operation code 001, the next result equals the registered A operand and the carry flag becomes 0.
- R4: With operation code 010, the next result is the low 16 bits of A+B and the carry flag is bit 16 of that sum. For example, B=0x7FFF with A=0x0001 gives 0x8000 with carry 0, and the carry ripples through every bit.
- R5: With operation code 011, the next result is the low 16 bits of A−B and the carry flag is 1 exactly when A ≥ B as unsigned numbers.
- R6: With operation code 100, the next result is A shifted left by 1 + B[1:0] positions (1 to 4). Vacated low bits fill with zeros and bits moved past bit 15 are lost. The carry flag becomes 0.
- R7: Operation code 101 yields A OR B and operation code 110 yields A AND B, bit by bit. The carry flag becomes 0 for both.
- R8: With operation code 111, the next result is the low 16 bits of the unsigned product A×B and the carry flag becomes 0.
- R9: The carry flag is written only by operation codes 010 and 011. Every other code except 000 clears it.
- R10: An operand register loads its input word at a clock edge only while its load enable is high, and otherwise keeps its value. A result captured at the same edge as a load uses the operand value from before that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| ld_a_i | input | 1 | Load enable for operand register A |
| ld_b_i | input | 1 | Load enable for operand register B |
| a_i | input | 16 | Input word for operand A |
| b_i | input | 16 | Input word for operand B |
| op_i | input | 3 | Operation code (000 hold … 111 multiply) |
| res_o | output | 16 | Registered result |
| cout_o | output | 1 | Registered carry flag from add or subtract |

## Verification
An operand load and a result capture can happen at the same clock edge. The captured result must then reflect the operand value from before the load, and the new value must appear only in the next operation. The bench provokes this overlap in a long run of random cycles, where both load enables toggle freely while operation codes change every cycle. A cycle-level model that updates its own operand copies only after it has computed the result judges every cycle. A stale or premature operand therefore shows up as a mismatch on the result or on the carry flag.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  // Operation codes; the subtract select and the carry update depend on these values.
  typedef enum logic [2:0] {
    OP_HOLD  = 3'b000,
    OP_PASSA = 3'b001,
    OP_ADD   = 3'b010,
    OP_SUB   = 3'b011,
    OP_SHL   = 3'b100,
    OP_OR    = 3'b101,
    OP_AND   = 3'b110,
    OP_MUL   = 3'b111
  } alu_op_e;

  // True for the two codes that drive the shared carry chain.
  function automatic logic is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/alu16_opreg.sv
module alu16_opreg #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk_i) begin
    if (rst_i)     q_r <= '0;
    else if (ld_i) q_r <= d_i;
  end

  assign q_o = q_r;

endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] y_eff;

  // Two's complement subtraction: inverted B plus a carry-in of one.
  assign y_eff    = y_i ^ {WIDTH{sub_i}};
  assign carry[0] = sub_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic prop;
    assign prop       = x_i[i] ^ y_eff[i];
    assign sum_o[i]   = prop ^ carry[i];
    assign carry[i+1] = (x_i[i] & y_eff[i]) | (prop & carry[i]);
  end

  assign cout_o = carry[WIDTH];

endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
  parameter int WIDTH      = 16,
  parameter int SHAMT_BITS = 2
) (
  input  logic [WIDTH-1:0]      a_i,
  input  logic [SHAMT_BITS-1:0] amt_i,
  output logic [WIDTH-1:0]      y_o
);

  localparam int STAGES = SHAMT_BITS + 1;

  logic [WIDTH-1:0] stg [STAGES];

  // Fixed first stage: the shift is never shorter than one place.
  assign stg[0] = {a_i[WIDTH-2:0], 1'b0};

  for (genvar k = 0; k < SHAMT_BITS; k++) begin : g_stage
    localparam int DIST = 1 << k;
    assign stg[k+1] = amt_i[k] ? {stg[k][WIDTH-1-DIST:0], {DIST{1'b0}}} : stg[k];
  end

  assign y_o = stg[STAGES-1];

endmodule

// File: rtl/alu16_mul.sv
module alu16_mul #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] p_o
);

  // Rows of an array multiplier, kept to the word width at every step.
  logic [WIDTH-1:0] acc [WIDTH+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_row
    logic [WIDTH-1:0] part;
    assign part     = b_i[i] ? (a_i << i) : '0;
    assign acc[i+1] = acc[i] + part;
  end

  assign p_o = acc[WIDTH];

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int SHAMT_BITS = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ld_a_i,
  input  logic             ld_b_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] a_q, b_q;
  logic [WIDTH-1:0] add_x, add_y, add_sum, shl_y, mul_p;
  logic             add_c, sub_sel, arith_en;
  logic [WIDTH-1:0] alu_res;
  logic             alu_c;
  logic [WIDTH-1:0] res_q;
  logic             cout_q;
  alu_op_e          op;

  assign op = alu_op_e'(op_i);

  alu16_opreg #(.WIDTH(WIDTH)) u_reg_a (
    .clk_i(clk_i), .rst_i(rst_i), .ld_i(ld_a_i), .d_i(a_i), .q_o(a_q)
  );

  alu16_opreg #(.WIDTH(WIDTH)) u_reg_b (
    .clk_i(clk_i), .rst_i(rst_i), .ld_i(ld_b_i), .d_i(b_i), .q_o(b_q)
  );

  // Full decode of the subtract select; carry-chain operands are isolated otherwise.
  assign sub_sel  = (op == OP_SUB);
  assign arith_en = is_arith(op);
  assign add_x    = arith_en ? a_q : '0;
  assign add_y    = arith_en ? b_q : '0;

  alu16_addsub #(.WIDTH(WIDTH)) u_addsub (
    .x_i(add_x), .y_i(add_y), .sub_i(sub_sel), .sum_o(add_sum), .cout_o(add_c)
  );

  alu16_shifter #(.WIDTH(WIDTH), .SHAMT_BITS(SHAMT_BITS)) u_shl (
    .a_i(a_q), .amt_i(b_q[SHAMT_BITS-1:0]), .y_o(shl_y)
  );

  alu16_mul #(.WIDTH(WIDTH)) u_mul (
    .a_i(a_q), .b_i(b_q), .p_o(mul_p)
  );

  always_comb begin
    alu_res = '0;
    alu_c   = 1'b0;
    unique case (op)
      OP_HOLD:  begin alu_res = res_q; alu_c = cout_q; end
      OP_PASSA: alu_res = a_q;
      OP_ADD,
      OP_SUB:   begin alu_res = add_sum; alu_c = add_c; end
      OP_SHL:   alu_res = shl_y;
      OP_OR:    alu_res = a_q | b_q;
      OP_AND:   alu_res = a_q & b_q;
      OP_MUL:   alu_res = mul_p;
      default:  alu_res = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_q  <= '0;
      cout_q <= 1'b0;
    end else if (op != OP_HOLD) begin
      res_q  <= alu_res;
      cout_q <= alu_c;
    end
  end

  assign res_o  = res_q;
  assign cout_o = cout_q;

endmodule

// File: rtl/alu16_chk.sv
module alu16_chk
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             ld_a_i,
  input logic             ld_b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] a_q,
  input logic [WIDTH-1:0] b_q,
  input logic [WIDTH-1:0] res_o,
  input logic             cout_o
);

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (res_o == '0) && !cout_o && (a_q == '0) && (b_q == '0)); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == OP_HOLD) |=> $stable(res_o) && $stable(cout_o)); // R2

  AST_PASS_A: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == OP_PASSA) |=> (res_o == $past(a_q))); // R3

  AST_ADD_SUM: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == OP_ADD) |=> ({cout_o, res_o} == ({1'b0, $past(a_q)} + {1'b0, $past(b_q)}))); // R4

  AST_SUB_BORROW: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == OP_SUB) |=> (cout_o == ($past(a_q) >= $past(b_q)))); // R5

  AST_SHIFT_ZERO_LSB: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == OP_SHL) |=> (res_o[0] == 1'b0)); // R6

  AST_NO_CARRY_OTHER: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i != OP_HOLD) && (op_i != OP_ADD) && (op_i != OP_SUB) |=> !cout_o); // R9

  AST_A_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !ld_a_i |=> $stable(a_q)); // R10

  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !ld_b_i |=> $stable(b_q)); // R10

endmodule

bind alu16_core alu16_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .ld_a_i(ld_a_i), .ld_b_i(ld_b_i), .op_i(op_i),
  .a_q(a_q), .b_q(b_q), .res_o(res_o), .cout_o(cout_o)
);

// File: tb/alu16_core_test.sv
module alu16_core_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        ld_a, ld_b;
  logic [15:0] a_in, b_in;
  logic [2:0]  op;
  logic [15:0] res;
  logic        cout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Bench-side model of the architectural state.
  logic [15:0] ma, mb, mres;
  logic        mc;

  localparam logic [15:0] VALS [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
                                        16'h7FFF, 16'h8000, 16'hFFFF, 16'h00FF,
                                        16'hFF00, 16'h5555, 16'hAAAA, 16'h1234};

  always #2.5 clk = ~clk;

  alu16_core uut (
    .clk_i(clk), .rst_i(rst), .ld_a_i(ld_a), .ld_b_i(ld_b),
    .a_i(a_in), .b_i(b_in), .op_i(op), .res_o(res), .cout_o(cout)
  );

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010: return "R4";
      3'b011: return "R5";
      3'b100: return "R6";
      3'b101: return "R7";
      3'b110: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Expected result from the arithmetic definitions of the requirements.
  task automatic model_op(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y);
    int unsigned sum, prod, sh;
    case (o)
      3'b000: ;
      3'b001: begin mres = x; mc = 1'b0; end
      3'b010: begin
        sum  = int'(x) + int'(y);
        mres = sum[15:0];
        mc   = sum[16];
      end
      3'b011: begin
        sum  = (int'(x) - int'(y) + 65536) % 65536;
        mres = sum[15:0];
        mc   = (x >= y);
      end
      3'b100: begin
        sh   = 1 + int'(y % 4);
        prod = (int'(x) * (1 << sh)) % 65536;
        mres = prod[15:0];
        mc   = 1'b0;
      end
      3'b101: begin mres = x | y; mc = 1'b0; end
      3'b110: begin mres = x & y; mc = 1'b0; end
      default: begin
        prod = (int'(x) * int'(y)) % 65536;
        mres = prod[15:0];
        mc   = 1'b0;
      end
    endcase
  endtask

  task automatic check(input string req, input string what);
    checks++;
    if (res !== mres || cout !== mc) begin
      errors++;
      $display("FAIL %s %s: res=%h cout=%b expected res=%h cout=%b",
               req, what, res, cout, mres, mc);
    end
  endtask

  // One cycle: drive at the falling edge, update the model at the rising edge, check just after.
  task automatic step(input logic la, input logic [15:0] av, input logic lb,
                      input logic [15:0] bv, input logic [2:0] o, input string what);
    @(negedge clk);
    ld_a = la; a_in = av; ld_b = lb; b_in = bv; op = o;
    @(posedge clk);
    model_op(o, ma, mb);
    if (la) ma = av;
    if (lb) mb = bv;
    #1;
    check(req_of(o), what);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ld_a = 1'b0; ld_b = 1'b0; op = 3'b000;
    @(posedge clk);
    ma = '0; mb = '0; mres = '0; mc = 1'b0;
    #1;
    check("R1", "reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ld_a = 1'b0; ld_b = 1'b0; a_in = '0; b_in = '0; op = 3'b000;
    ma = '0; mb = '0; mres = '0; mc = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1", "initial reset state");
    @(negedge clk);
    rst = 1'b0;

    // R4: full carry ripple from 0x7FFF to 0x8000.
    step(1, 16'h0000, 1, 16'h7FFF, 3'b000, "R4 load");
    step(0, 16'h0000, 0, 16'h0000, 3'b010, "R4 add 0+7FFF");
    step(1, 16'h0001, 0, 16'h0000, 3'b000, "R4 load A=1");
    step(0, 16'h0000, 0, 16'h0000, 3'b010, "R4 ripple to 8000");

    // Sweep every operation over every corner-value pair.
    for (int o = 1; o < 8; o++) begin
      for (int i = 0; i < 12; i++) begin
        for (int j = 0; j < 12; j++) begin
          step(1, VALS[i], 1, VALS[j], 3'b000, "R10 load before op");
          step(0, 16'h0000, 0, 16'h0000, 3'(o), "sweep");
        end
      end
    end

    // R9: carry set by add, then cleared by a non-arithmetic op; R2: hold keeps it.
    step(1, 16'hFFFF, 1, 16'h0001, 3'b000, "R9 load");
    step(0, 16'h0000, 0, 16'h0000, 3'b010, "R9 add sets carry");
    step(0, 16'h0000, 0, 16'h0000, 3'b000, "R2 hold keeps carry");
    step(0, 16'h0000, 0, 16'h0000, 3'b110, "R9 AND clears carry");

    // R10: disabled load ignores the data inputs, visible through pass A and OR.
    step(0, 16'hDEAD, 0, 16'hBEEF, 3'b001, "R10 A kept when ld_a low");
    step(0, 16'hDEAD, 0, 16'hBEEF, 3'b101, "R10 B kept when ld_b low");

    // R10: load and capture at the same edge use the old operands.
    step(1, 16'h1111, 1, 16'h2222, 3'b011, "R10 overlap uses old operands");
    step(0, 16'h0000, 0, 16'h0000, 3'b010, "R10 new operands next cycle");

    // R1: mid-run reset clears operands, seen through pass A.
    step(1, 16'hABCD, 1, 16'h0F0F, 3'b111, "R8 before reset");
    do_reset();
    step(0, 16'h0000, 0, 16'h0000, 3'b001, "R1 operand A cleared");
    step(0, 16'h0000, 0, 16'h0000, 3'b101, "R1 operand B cleared");

    // Random overlap of loads and operations.
    for (int n = 0; n < 2000; n++) begin
      step(1'($urandom_range(0, 1)), 16'($urandom), 1'($urandom_range(0, 1)),
           16'($urandom), 3'($urandom_range(0, 7)), "random overlap");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule